// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block is the control core of a contact smart-card interface. It brings a card up and tears it down in a fixed order. The analog parts (voltage pump, card supply regulator, line drivers, temperature and current sensing) sit outside it. They appear here only as enable outputs and flag inputs. All timing comes from a slow tick taken from an internal oscillator. A time unit T is a parameter counted in ticks (64 by default), and every step of a sequence falls on a multiple of T/2.

A host opens a session by pulling an active-low command low while a card is present. The block then raises the pump and supply enables, opens the data lines and the card clock, and finally passes the host's reset request through to the card. It closes the session in reverse order when the command returns high. A card removal, an overcurrent or an overtemperature during a session forces the same teardown. Each of these also pulls an active-low status output low and holds it there until the host releases the command. A supply-low alarm also forces the teardown, but it leaves the status high. The alarm also locks the block out of any new session for a hold time after it clears.

Top module: `scs_power_seq`

## Requirements
- R1: After reset all five enables are low. Whenever the command is high, the status output equals card presence.
- R2: With the block idle, no lockout and a card present, a clock edge that samples the command low raises pump_en and vcc_en together on that edge.
- R3: io_en rises once 4T (8 half-units) of ticks have been counted since the session started.
- R4: During a session, clk_en rises at 4T if the reset request is low. If the request is high at 4T, clk_en rises when the request goes low before 7T. From 7T on, clk_en is high whatever the request does.
- R5: Before 7T card_rst is held low. From 7T on, card_rst follows the reset request combinationally.
- R6: At teardown, card_rst drops on the starting edge. clk_en follows at T/2, io_en at T, vcc_en at 1.5T and pump_en at 5T. A line that was not yet on stays off.
- R7: A card counts as present when card_in_n is low or card_in is high.
- R8: During a session, card absence, over_current or over_temp starts the teardown on that edge. The status goes low from that edge and stays low while the command stays low, whatever the presence inputs do.
- R9: supply_low during a session starts the teardown, and the status stays high.
- R10: While the command is high, status_n is 1 for a card present and 0 for no card, even during a teardown.
- R11: No session starts while supply_low is high, nor for HOLD_TICKS ticks after it falls. The same lockout applies after reset.
- R12: If the command is still low when a teardown ends, a new session needs the command to go high and then fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle pulse per slow oscillator period |
| cmd_n | input | 1 | Session command, active low |
| rst_req | input | 1 | Card reset request from the host, active high |
| card_in_n | input | 1 | Presence switch, active low |
| card_in | input | 1 | Presence switch, active high |
| over_current | input | 1 | Card supply overload flag |
| over_temp | input | 1 | Overtemperature flag |
| supply_low | input | 1 | Host supply under-voltage alarm |
| pump_en | output | 1 | Voltage pump enable |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Data line enable (low means high impedance) |
| clk_en | output | 1 | Card clock enable (low means clock held low) |
| card_rst | output | 1 | Reset level driven to the card |
| status_n | output | 1 | Fault or presence status, active low |

## Verification
Activation is run in three ways. With the reset request low, the clock opens together with the data lines. With the request high and then released inside the window, the clock opens at the release. With the request held high past 7T, the clock is forced on. Faults are injected at three points: during activation before the lines open, in the steady session, and with presence bounce after a removal. These separate the latched status from a live presence view. They also show that a teardown does not turn on a line that was never enabled. An alarm in a session and an alarm while idle separate the silent teardown from the hold lockout. A long stretch of random commands, requests, presence changes and flags, with irregular ticks, then compares every output each cycle against a tick-count model built from the step times above.

// File: rtl/scs_pkg.sv
// Shared types and step positions for the smart card power sequencer.
// Step positions are counted in half time units (T/2) from the start of a phase.
package scs_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_SESSION  = 2'd1,
        SEQ_TEARDOWN = 2'd2,
        SEQ_REARM    = 2'd3
    } seq_state_t;

    localparam int STEP_W = 4;

    // Activation steps (from session start)
    localparam logic [STEP_W-1:0] UP_IO  = 4'd8;   // 4T
    localparam logic [STEP_W-1:0] UP_RST = 4'd14;  // 7T

    // Teardown steps (from teardown start)
    localparam logic [STEP_W-1:0] DN_CLK  = 4'd1;  // T/2
    localparam logic [STEP_W-1:0] DN_IO   = 4'd2;  // T
    localparam logic [STEP_W-1:0] DN_VCC  = 4'd3;  // 1.5T
    localparam logic [STEP_W-1:0] DN_PUMP = 4'd10; // 5T

endpackage

// File: rtl/scs_halfstep_timer.sv
// Half-unit step timer.
// Counts slow ticks and advances a step counter once per UNIT_TICKS/2 ticks.
// Assumes UNIT_TICKS is even and at least 2. clear has priority over counting;
// freeze stops counting so the step value saturates where the caller wants it.
module scs_halfstep_timer
    import scs_pkg::*;
#(
    parameter int UNIT_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clear,
    input  logic              freeze,
    output logic [STEP_W-1:0] step
);

    localparam int HALF = UNIT_TICKS / 2;
    localparam int TC_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(HALF - 1);

    logic [TC_W-1:0] tick_cnt;

    // Tick prescaler and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            step     <= '0;
        end else if (clear) begin
            tick_cnt <= '0;
            step     <= '0;
        end else if (tick && !freeze) begin
            if (tick_cnt == TC_LAST) begin
                tick_cnt <= '0;
                step     <= step + 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/scs_supply_guard.sv
// Supply lockout guard.
// Holds 'blocked' high while the supply alarm is asserted and for HOLD_TICKS
// slow ticks after it clears. Reset loads the full hold so that power-up is
// also locked out. Assumes HOLD_TICKS >= 1.
module scs_supply_guard #(
    parameter int HOLD_TICKS = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_low,
    output logic blocked
);

    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_TICKS);

    logic [HW-1:0] hold_cnt;

    // Reload on alarm, count down on ticks afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= HOLD_LOAD;
        end else if (supply_low) begin
            hold_cnt <= HOLD_LOAD;
        end else if (tick && (hold_cnt != '0)) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // Lockout is active during the alarm and while the hold runs
    always_comb begin
        blocked = supply_low || (hold_cnt != '0);
    end

endmodule

// File: rtl/scs_fault_monitor.sv
// Presence decode, fault latch and status output.
// A card is present if either switch reports it. During a session, removal,
// overcurrent or overtemperature raise fault_now. The latch keeps the event
// until the command goes high, so switch bounce cannot clear it. The status
// shows presence outside a session and the latched fault inside one.
module scs_fault_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_n,
    input  logic card_in_n,
    input  logic card_in,
    input  logic over_current,
    input  logic over_temp,
    input  logic in_session,
    input  logic engaged,
    output logic card_present,
    output logic fault_now,
    output logic status_n
);

    logic flt_lat;

    // Presence and live fault decode
    always_comb begin
        card_present = !card_in_n || card_in;
        fault_now    = in_session && (!card_present || over_current || over_temp);
    end

    // Fault latch, released only by the command going high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_lat <= 1'b0;
        end else if (cmd_n) begin
            flt_lat <= 1'b0;
        end else if (fault_now) begin
            flt_lat <= 1'b1;
        end
    end

    // Status multiplexer: presence view or fault view
    always_comb begin
        if (cmd_n || !engaged) begin
            status_n = card_present;
        end else begin
            status_n = !flt_lat;
        end
    end

endmodule

// File: rtl/scs_seq_ctrl.sv
// Session state machine and enable decode.
// Assumes all inputs are synchronous to clk. Enables are decoded from the
// state and the half-unit step of the timer. At teardown start it records
// which of the data lines and clock were on, so a teardown never turns on
// a line that activation had not reached.
module scs_seq_ctrl
    import scs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_n,
    input  logic              rst_req,
    input  logic              supply_low,
    input  logic              card_present,
    input  logic              fault_now,
    input  logic              blocked,
    input  logic [STEP_W-1:0] step,
    output logic              timer_clear,
    output logic              timer_freeze,
    output logic              in_session,
    output logic              engaged,
    output logic              pump_en,
    output logic              vcc_en,
    output logic              io_en,
    output logic              clk_en,
    output logic              card_rst
);

    seq_state_t st, st_nxt;
    logic       stop;
    logic       clk_run;
    logic       io_was;
    logic       clk_was;

    // Session stop request: host release, fault or supply alarm
    always_comb begin
        stop = (st == SEQ_SESSION) && (cmd_n || fault_now || supply_low);
    end

    // Next state and timer control
    always_comb begin
        st_nxt      = st;
        timer_clear = 1'b0;
        case (st)
            SEQ_IDLE: begin
                timer_clear = 1'b1;
                if (!cmd_n && !blocked && card_present) begin
                    st_nxt = SEQ_SESSION;
                end
            end
            SEQ_SESSION: begin
                if (stop) begin
                    st_nxt      = SEQ_TEARDOWN;
                    timer_clear = 1'b1;
                end
            end
            SEQ_TEARDOWN: begin
                if (step == DN_PUMP) begin
                    st_nxt      = cmd_n ? SEQ_IDLE : SEQ_REARM;
                    timer_clear = 1'b1;
                end
            end
            SEQ_REARM: begin
                timer_clear = 1'b1;
                if (cmd_n) begin
                    st_nxt = SEQ_IDLE;
                end
            end
            default: begin
                st_nxt      = SEQ_IDLE;
                timer_clear = 1'b1;
            end
        endcase
    end

    // Saturate the step counter once the session is fully up
    always_comb begin
        timer_freeze = (st == SEQ_SESSION) && (step >= UP_RST);
        in_session   = (st == SEQ_SESSION);
        engaged      = (st != SEQ_IDLE);
    end

    // Enable decode from state and step
    always_comb begin
        pump_en  = 1'b0;
        vcc_en   = 1'b0;
        io_en    = 1'b0;
        clk_en   = 1'b0;
        card_rst = 1'b0;
        case (st)
            SEQ_SESSION: begin
                pump_en  = 1'b1;
                vcc_en   = 1'b1;
                io_en    = (step >= UP_IO);
                clk_en   = (step >= UP_RST) || clk_run || ((step >= UP_IO) && !rst_req);
                card_rst = (step >= UP_RST) && rst_req;
            end
            SEQ_TEARDOWN: begin
                pump_en = (step < DN_PUMP);
                vcc_en  = (step < DN_VCC);
                io_en   = io_was && (step < DN_IO);
                clk_en  = clk_was && (step < DN_CLK);
            end
            default: begin
                pump_en = 1'b0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SEQ_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Clock-started memory, valid only inside a session
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_run <= 1'b0;
        end else if (st != SEQ_SESSION) begin
            clk_run <= 1'b0;
        end else begin
            clk_run <= clk_en;
        end
    end

    // Snapshot of line states at teardown start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_was  <= 1'b0;
            clk_was <= 1'b0;
        end else if (stop) begin
            io_was  <= io_en;
            clk_was <= clk_en;
        end
    end

endmodule

// File: rtl/scs_power_seq.sv
// Smart card power sequencer top.
// Connects the step timer, supply guard, fault monitor and session control.
// Timing: T = UNIT_TICKS slow ticks, all steps on multiples of T/2; the
// supply lockout lasts HOLD_TICKS ticks. All inputs are assumed synchronous.
module scs_power_seq
    import scs_pkg::*;
#(
    parameter int UNIT_TICKS = 64,
    parameter int HOLD_TICKS = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cmd_n,
    input  logic rst_req,
    input  logic card_in_n,
    input  logic card_in,
    input  logic over_current,
    input  logic over_temp,
    input  logic supply_low,
    output logic pump_en,
    output logic vcc_en,
    output logic io_en,
    output logic clk_en,
    output logic card_rst,
    output logic status_n
);

    logic [STEP_W-1:0] step;
    logic              timer_clear;
    logic              timer_freeze;
    logic              blocked;
    logic              card_present;
    logic              fault_now;
    logic              in_session;
    logic              engaged;

    scs_halfstep_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clear  (timer_clear),
        .freeze (timer_freeze),
        .step   (step)
    );

    scs_supply_guard #(.HOLD_TICKS(HOLD_TICKS)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .supply_low (supply_low),
        .blocked    (blocked)
    );

    scs_fault_monitor u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_n        (cmd_n),
        .card_in_n    (card_in_n),
        .card_in      (card_in),
        .over_current (over_current),
        .over_temp    (over_temp),
        .in_session   (in_session),
        .engaged      (engaged),
        .card_present (card_present),
        .fault_now    (fault_now),
        .status_n     (status_n)
    );

    scs_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_n        (cmd_n),
        .rst_req      (rst_req),
        .supply_low   (supply_low),
        .card_present (card_present),
        .fault_now    (fault_now),
        .blocked      (blocked),
        .step         (step),
        .timer_clear  (timer_clear),
        .timer_freeze (timer_freeze),
        .in_session   (in_session),
        .engaged      (engaged),
        .pump_en      (pump_en),
        .vcc_en       (vcc_en),
        .io_en        (io_en),
        .clk_en       (clk_en),
        .card_rst     (card_rst)
    );

endmodule

// File: rtl/scs_power_seq_chk.sv
// Property checker for the smart card power sequencer, bound to the top.
// It checks only the ordering and gating relations visible at the ports.
module scs_power_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_n,
    input logic rst_req,
    input logic card_in_n,
    input logic card_in,
    input logic supply_low,
    input logic pump_en,
    input logic vcc_en,
    input logic io_en,
    input logic clk_en,
    input logic card_rst,
    input logic status_n
);

    AST_START_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_en) |-> $rose(vcc_en)); // R2

    AST_IO_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> vcc_en); // R3

    AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> io_en); // R4

    AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> clk_en); // R5

    AST_RST_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> rst_req); // R5

    AST_SUPPLY_NEEDS_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_en |-> pump_en); // R6

    AST_NO_START_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_en && card_in_n && !card_in) |=> !pump_en); // R7

    AST_STATUS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_n |-> (status_n == (!card_in_n || card_in))); // R10

    AST_NO_START_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_low && !pump_en) |=> !pump_en); // R11

endmodule

bind scs_power_seq scs_power_seq_chk u_chk (.*);

// File: tb/scs_power_seq_test.sv
`timescale 1ns/1ps
module scs_power_seq_test;

    localparam int U    = 8;
    localparam int H    = U / 2;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cmd_n = 1'b1;
    logic rst_req = 1'b0;
    logic card_in_n = 1'b1;
    logic card_in = 1'b0;
    logic over_current = 1'b0;
    logic over_temp = 1'b0;
    logic supply_low = 1'b0;
    logic pump_en, vcc_en, io_en, clk_en, card_rst, status_n;

    int checks = 0;
    int errors = 0;
    bit tick_rand = 1'b0;
    bit done = 1'b0;

    // Reference model state: 0 idle, 1 session, 2 teardown, 3 rearm
    int m_st = 0;
    int m_e = 0;
    int m_hold = HOLD;
    bit m_clkrun = 0, m_io_was = 0, m_clk_was = 0, m_flt = 0;

    always #4 clk = ~clk; // 125 MHz

    scs_power_seq #(.UNIT_TICKS(U), .HOLD_TICKS(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_n(cmd_n), .rst_req(rst_req),
        .card_in_n(card_in_n), .card_in(card_in), .over_current(over_current),
        .over_temp(over_temp), .supply_low(supply_low), .pump_en(pump_en),
        .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst),
        .status_n(status_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit present_f();
        return !card_in_n || card_in;
    endfunction

    function automatic bit exp_pump();
        return (m_st == 1) || (m_st == 2 && m_e / H < 10);
    endfunction
    function automatic bit exp_vcc();
        return (m_st == 1) || (m_st == 2 && m_e / H < 3);
    endfunction
    function automatic bit exp_io();
        return (m_st == 1 && m_e / H >= 8) || (m_st == 2 && m_io_was && m_e / H < 2);
    endfunction
    function automatic bit exp_clk();
        if (m_st == 1) return (m_e / H >= 14) || m_clkrun || (m_e / H >= 8 && !rst_req);
        return (m_st == 2) && m_clk_was && (m_e / H < 1);
    endfunction
    function automatic bit exp_rst();
        return (m_st == 1) && (m_e / H >= 14) && rst_req;
    endfunction
    function automatic bit exp_status();
        if (cmd_n || m_st == 0) return present_f();
        return !m_flt;
    endfunction

    // Model update at a clock edge, from the inputs sampled there
    task automatic model_edge();
        bit fault, stop, blocked, io_c, clk_c;
        if (!rst_n) begin
            m_st = 0; m_e = 0; m_hold = HOLD; m_clkrun = 0;
            m_io_was = 0; m_clk_was = 0; m_flt = 0;
            return;
        end
        fault   = (m_st == 1) && (!present_f() || over_current || over_temp);
        stop    = (m_st == 1) && (cmd_n || fault || supply_low);
        blocked = supply_low || (m_hold != 0);
        io_c    = exp_io();
        clk_c   = exp_clk();
        if (cmd_n) m_flt = 0; else if (fault) m_flt = 1;
        if (supply_low) m_hold = HOLD; else if (tick && m_hold > 0) m_hold--;
        case (m_st)
            0: if (!cmd_n && !blocked && present_f()) begin m_st = 1; m_e = 0; m_clkrun = 0; end
            1: if (stop) begin
                   m_st = 2; m_e = 0; m_io_was = io_c; m_clk_was = clk_c;
               end else begin
                   m_clkrun = clk_c;
                   if (tick && m_e < 14 * H) m_e++;
               end
            2: if (m_e / H == 10) begin m_st = cmd_n ? 0 : 3; m_e = 0; end
               else if (tick) m_e++;
            default: if (cmd_n) m_st = 0;
        endcase
    endtask

    // One cycle: settle, compare all outputs, advance past the edge
    task automatic step();
        tick = tick_rand ? 1'($urandom % 2) : 1'b1;
        #1;
        if (rst_n) begin
            chk((m_st == 2) ? "R6 pump_en" : "R2 pump_en", pump_en, exp_pump());
            chk((m_st == 2) ? "R6 vcc_en" : "R2 vcc_en", vcc_en, exp_vcc());
            chk((m_st == 2) ? "R6 io_en" : "R3 io_en", io_en, exp_io());
            chk((m_st == 2) ? "R6 clk_en" : "R4 clk_en", clk_en, exp_clk());
            chk("R5 card_rst", card_rst, exp_rst());
            chk((cmd_n || m_st == 0) ? "R10 status_n" : "R8 status_n", status_n, exp_status());
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        run(3);
        rst_n = 1'b1;
        // R1: reset state, no card
        step();
        chk("R1 pump_en after reset", pump_en, 1'b0);
        chk("R1 io_en after reset", io_en, 1'b0);
        chk("R1 status_n no card", status_n, 1'b0);

        // R11: lockout after reset blocks a start
        card_in = 1'b1; cmd_n = 1'b0;
        run(8);
        chk("R11 no start during power-up hold", pump_en, 1'b0);
        cmd_n = 1'b1;
        run(HOLD + 2);

        // R3/R4: normal activation with request low
        rst_req = 1'b0; cmd_n = 1'b0;
        run(16 * H);
        chk("R3 io open", io_en, 1'b1);
        chk("R4 clock running", clk_en, 1'b1);
        rst_req = 1'b1; step();
        chk("R5 reset passes", card_rst, 1'b1);
        rst_req = 1'b0; step();
        chk("R5 reset follows low", card_rst, 1'b0);
        cmd_n = 1'b1;
        run(12 * H);
        chk("R6 pump off after teardown", pump_en, 1'b0);

        // R4: request high at start, released inside window
        rst_req = 1'b1; cmd_n = 1'b0;
        run(10 * H);
        chk("R4 clock held while request high", clk_en, 1'b0);
        rst_req = 1'b0; step();
        chk("R4 clock starts on release", clk_en, 1'b1);
        rst_req = 1'b1; step();
        chk("R4 clock stays after start", clk_en, 1'b1);
        cmd_n = 1'b1; rst_req = 1'b0;
        run(12 * H);

        // R4/R5: request held high through 7T
        rst_req = 1'b1; cmd_n = 1'b0;
        run(16 * H);
        chk("R4 clock forced at 7T", clk_en, 1'b1);
        chk("R5 reset copies high request", card_rst, 1'b1);
        cmd_n = 1'b1; step();
        chk("R6 reset drops at once", card_rst, 1'b0);
        rst_req = 1'b0;
        run(12 * H);

        // R8/R12: removal with bounce
        cmd_n = 1'b0;
        run(16 * H);
        card_in = 1'b0; step();
        chk("R8 status low on removal", status_n, 1'b0);
        card_in = 1'b1; run(3);
        card_in = 1'b0; run(2);
        card_in = 1'b1;
        run(12 * H);
        chk("R12 no restart while command low", pump_en, 1'b0);
        chk("R8 status stays latched", status_n, 1'b0);
        cmd_n = 1'b1; step();
        chk("R10 status shows presence", status_n, 1'b1);

        // R7: each presence input alone
        card_in = 1'b0; card_in_n = 1'b0; step();
        chk("R7 low-active switch counts", status_n, 1'b1);
        card_in_n = 1'b1; step();
        chk("R7 no switch means absent", status_n, 1'b0);
        card_in = 1'b1;

        // R8/R6: overcurrent during activation, then re-arm
        cmd_n = 1'b0;
        run(5 * H);
        over_current = 1'b1; step(); over_current = 1'b0;
        chk("R8 status low on overcurrent", status_n, 1'b0);
        chk("R6 io never opened", io_en, 1'b0);
        run(12 * H);
        cmd_n = 1'b1; run(2);
        cmd_n = 1'b0;
        run(16 * H);
        chk("R12 new session after re-arm", io_en, 1'b1);
        over_temp = 1'b1; step(); over_temp = 1'b0;
        chk("R8 status low on overtemp", status_n, 1'b0);
        run(12 * H);
        cmd_n = 1'b1; run(2);

        // R9: alarm during a session
        cmd_n = 1'b0;
        run(16 * H);
        supply_low = 1'b1; step();
        chk("R9 status stays high on alarm", status_n, 1'b1);
        run(3);
        supply_low = 1'b0;
        run(12 * H);
        chk("R9 teardown completed", pump_en, 1'b0);
        cmd_n = 1'b1; run(HOLD + 2);

        // R11: alarm while idle, then hold
        supply_low = 1'b1; step(); supply_low = 1'b0;
        cmd_n = 1'b0;
        run(10);
        chk("R11 blocked during hold", pump_en, 1'b0);
        run(HOLD);
        chk("R11 start after hold", pump_en, 1'b1);
        cmd_n = 1'b1;
        run(12 * H);

        // Random phase with irregular ticks
        tick_rand = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 90 == 0) cmd_n = ~cmd_n;
            if ($urandom % 20 == 0) rst_req = ~rst_req;
            if ($urandom % 150 == 0) card_in = ~card_in;
            if ($urandom % 300 == 0) card_in_n = ~card_in_n;
            over_current = ($urandom % 400 == 0);
            over_temp    = ($urandom % 400 == 0);
            supply_low   = ($urandom % 600 == 0);
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule